// File: doc/BRIEF.md
# Bus Cycle Break Comparator

This block is a debug break unit. It watches every bus cycle and raises a break interrupt request when a cycle meets a set of programmed conditions. Each monitored cycle carries an address, a master (CPU or DMA), an access kind (fetch or data), a direction and an operand size. Software programs a 32-bit break address, a 32-bit address mask and a 16-bit cycle condition register. It does this through a simple register port with per-byte write enables.

In the normal mode the full 32-bit main-bus address is compared under the mask. In the narrow mode one of two 16-bit side buses (X or Y) is compared instead. Only address bits 15..1 take part, and each bus uses its own half of the break address and of the mask. A match sets a sticky break flag. The interrupt output is that flag gated by an enable bit.

There are two reset classes. The power-on reset clears everything. The soft reset, used for module and software standby, clears only the flag.

Top module: `bus_break_unit`

## Requirements
- R1: While `rstPowerN` is low, every register reads 0, the flag is 0 and `breakIrq` is 0.
- R2: A cycle with `softReset` high clears the flag. The address, mask and cycle registers keep their values.
- R3: With `xye`=0, a cycle matches on address when `(busAddr ^ breakAddr) & ~mask` is zero. A mask bit of 1 removes that address bit from the comparison.
- R4: With `xye`=1 and `xys`=0, `xAddr[15:1]` is compared with break address bits 31..17 under mask bits 31..17. With `xys`=1, `yAddr[15:1]` is compared with break address bits 15..1 under mask bits 15..1. Address bit 0 and mask bits 16 and 0 have no effect in this mode.
- R5: The fields cp (bits 7:6, against `busDma`), id (bits 5:4, against `busData`) and rw (bits 3:2, against `busWrite`) use one encoding. 00 never matches. 01 matches when the signal is 0. 10 matches when it is 1. 11 matches either value.
- R6: The sz field (bits 1:0) accepts any size when it is 00. Otherwise it matches only when `busSize` equals it (01 byte, 10 word, 11 long).
- R7: A cycle with `busValid` and a full match sets the flag on that clock edge. The flag stays set until software writes 1 to STATUS bit 0. A match in the same cycle as the clear wins. The flag reads at STATUS bit 0.
- R8: `breakIrq` equals the flag ANDed with cycle register bit 15 (ie). Bits 14..10 of the cycle register always read 0. The other bits are ie 15, xye 9, xys 8.
- R9: Register select codes are 0 address[31:16], 1 address[15:0], 2 mask[31:16], 3 mask[15:0], 4 cycle and 5 status. `regByteEn` bit 0 writes data bits 7..0 and bit 1 writes bits 15..8. A write shows on `regRdata` and applies to bus cycles from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstPowerN | input | 1 | Power-on / hardware standby reset, active low, clears all state |
| softReset | input | 1 | Module / software standby reset, clears only the break flag |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regByteEn | input | 2 | Byte enables for the write |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data of the selected register |
| busValid | input | 1 | A bus cycle is present this clock |
| busAddr | input | 32 | Main-bus address |
| xAddr | input | 16 | X-bus address |
| yAddr | input | 16 | Y-bus address |
| busDma | input | 1 | 0 CPU cycle, 1 DMA cycle |
| busData | input | 1 | 0 instruction fetch, 1 data access |
| busWrite | input | 1 | 0 read, 1 write |
| busSize | input | 2 | 01 byte, 10 word, 11 longword |
| breakIrq | output | 1 | Break interrupt request |

## Verification
A wrong compare or qualifier decode shows on `breakIrq` one clock after the offending bus cycle, as long as ie is set. Because the flag is sticky, a false match then persists until it is cleared. The bench compares `breakIrq` against a behavioural model on every clock. A corrupted register or a byte enable that is ignored shows at once on `regRdata` when that register is selected. A flag that clears or sets wrongly shows on the next clock through the status readback, even with ie at 0.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  typedef struct packed {
    logic       ie;
    logic [4:0] rsvd;
    logic       xye;
    logic       xys;
    logic [1:0] cp;
    logic [1:0] id;
    logic [1:0] rw;
    logic [1:0] sz;
  } cyc_t;

  typedef struct packed {
    logic [1:0] addrHi;
    logic [1:0] addrLo;
    logic [1:0] maskHi;
    logic [1:0] maskLo;
    logic [1:0] cyc;
    logic       clrFlag;
  } strb_t;

  localparam logic [2:0] SEL_ADDR_HI = 3'd0;
  localparam logic [2:0] SEL_ADDR_LO = 3'd1;
  localparam logic [2:0] SEL_MASK_HI = 3'd2;
  localparam logic [2:0] SEL_MASK_LO = 3'd3;
  localparam logic [2:0] SEL_CYC     = 3'd4;
  localparam logic [2:0] SEL_STATUS  = 3'd5;
endpackage

// File: rtl/bbu_ctrl.sv
module bbu_ctrl
  import bbu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 16
) (
  input  logic              regWr,
  input  logic [2:0]        regSel,
  input  logic [1:0]        regByteEn,
  input  logic              clrBit,
  input  logic [ADDR_W-1:0] addrReg,
  input  logic [ADDR_W-1:0] maskReg,
  input  cyc_t              cycReg,
  input  logic              flag,
  output strb_t             strb,
  output logic [REG_W-1:0]  regRdata
);
  localparam int HALF = ADDR_W / 2;

  always_comb begin
    strb = '0;
    if (regWr) begin
      unique case (regSel)
        SEL_ADDR_HI: strb.addrHi  = regByteEn;
        SEL_ADDR_LO: strb.addrLo  = regByteEn;
        SEL_MASK_HI: strb.maskHi  = regByteEn;
        SEL_MASK_LO: strb.maskLo  = regByteEn;
        SEL_CYC:     strb.cyc     = regByteEn;
        SEL_STATUS:  strb.clrFlag = regByteEn[0] & clrBit;
        default:     strb = '0;
      endcase
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_ADDR_HI: regRdata = addrReg[ADDR_W-1:HALF];
      SEL_ADDR_LO: regRdata = addrReg[HALF-1:0];
      SEL_MASK_HI: regRdata = maskReg[ADDR_W-1:HALF];
      SEL_MASK_LO: regRdata = maskReg[HALF-1:0];
      SEL_CYC:     regRdata = cycReg;
      SEL_STATUS:  regRdata = {{(REG_W-1){1'b0}}, flag};
      default:     regRdata = '0;
    endcase
  end
endmodule

// File: rtl/bbu_datapath.sv
module bbu_datapath
  import bbu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstPowerN,
  input  logic              softReset,
  input  strb_t             strb,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  xAddr,
  input  logic [REG_W-1:0]  yAddr,
  input  logic              busDma,
  input  logic              busData,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  output logic [ADDR_W-1:0] addrReg,
  output logic [ADDR_W-1:0] maskReg,
  output cyc_t              cycReg,
  output logic              flag,
  output logic              breakIrq
);
  localparam int HALF = ADDR_W / 2;
  localparam logic [REG_W-1:0] NARROW_CARE = {{(REG_W-1){1'b1}}, 1'b0};

  function automatic logic [REG_W-1:0] mergeBytes(
    input logic [REG_W-1:0] old, input logic [REG_W-1:0] nw, input logic [1:0] be);
    logic [REG_W-1:0] r;
    r = old;
    if (be[0]) r[7:0] = nw[7:0];
    if (be[1]) r[REG_W-1:8] = nw[REG_W-1:8];
    return r;
  endfunction

  function automatic logic kindOk(input logic [1:0] fld, input logic sig);
    return (fld == 2'b11) || (fld == 2'b01 && !sig) || (fld == 2'b10 && sig);
  endfunction

  logic addrOk, qualOk, hit;

  always_comb begin
    if (!cycReg.xye)
      addrOk = ((busAddr ^ addrReg) & ~maskReg) == '0;
    else if (!cycReg.xys)
      addrOk = ((xAddr ^ addrReg[ADDR_W-1:HALF]) & ~maskReg[ADDR_W-1:HALF] & NARROW_CARE) == '0;
    else
      addrOk = ((yAddr ^ addrReg[HALF-1:0]) & ~maskReg[HALF-1:0] & NARROW_CARE) == '0;
    qualOk = kindOk(cycReg.cp, busDma) && kindOk(cycReg.id, busData) &&
             kindOk(cycReg.rw, busWrite) &&
             (cycReg.sz == 2'b00 || cycReg.sz == busSize);
    hit = busValid && addrOk && qualOk;
  end

  always_ff @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN) begin
      addrReg <= '0;
      maskReg <= '0;
      cycReg  <= '0;
      flag    <= 1'b0;
    end else begin
      addrReg[ADDR_W-1:HALF] <= mergeBytes(addrReg[ADDR_W-1:HALF], wdata, strb.addrHi);
      addrReg[HALF-1:0]      <= mergeBytes(addrReg[HALF-1:0], wdata, strb.addrLo);
      maskReg[ADDR_W-1:HALF] <= mergeBytes(maskReg[ADDR_W-1:HALF], wdata, strb.maskHi);
      maskReg[HALF-1:0]      <= mergeBytes(maskReg[HALF-1:0], wdata, strb.maskLo);
      begin
        cyc_t nc;
        nc = mergeBytes(cycReg, wdata, strb.cyc);
        nc.rsvd = '0;
        cycReg <= nc;
      end
      if (softReset)         flag <= 1'b0;
      else if (hit)          flag <= 1'b1;
      else if (strb.clrFlag) flag <= 1'b0;
    end
  end

  assign breakIrq = flag & cycReg.ie;

  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstPowerN)
    hit && !softReset |=> flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstPowerN)
    flag && !strb.clrFlag && !softReset |=> flag); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstPowerN)
    strb.clrFlag && !hit && !softReset |=> !flag); // R7
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rstPowerN)
    softReset |=> !flag); // R2
  AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (!rstPowerN)
    softReset && strb == '0 |=> $stable(addrReg) && $stable(maskReg) && $stable(cycReg)); // R2
  AST_NEVER_KIND: assert property (@(posedge clk) disable iff (!rstPowerN)
    (cycReg.cp == 2'b00 || cycReg.id == 2'b00 || cycReg.rw == 2'b00) |-> !hit); // R5
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstPowerN,
  input  logic              softReset,
  input  logic              regWr,
  input  logic [2:0]        regSel,
  input  logic [1:0]        regByteEn,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  xAddr,
  input  logic [REG_W-1:0]  yAddr,
  input  logic              busDma,
  input  logic              busData,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  output logic              breakIrq
);
  strb_t             strb;
  logic [ADDR_W-1:0] addrReg, maskReg;
  cyc_t              cycReg;
  logic              flag;

  bbu_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W)) uCtrl (
    .regWr(regWr), .regSel(regSel), .regByteEn(regByteEn), .clrBit(regWdata[0]),
    .addrReg(addrReg), .maskReg(maskReg), .cycReg(cycReg), .flag(flag),
    .strb(strb), .regRdata(regRdata));

  bbu_datapath #(.ADDR_W(ADDR_W), .REG_W(REG_W)) uDp (
    .clk(clk), .rstPowerN(rstPowerN), .softReset(softReset), .strb(strb),
    .wdata(regWdata), .busValid(busValid), .busAddr(busAddr), .xAddr(xAddr),
    .yAddr(yAddr), .busDma(busDma), .busData(busData), .busWrite(busWrite),
    .busSize(busSize), .addrReg(addrReg), .maskReg(maskReg), .cycReg(cycReg),
    .flag(flag), .breakIrq(breakIrq));

  AST_IRQ_OFF_IN_RESET: assert property (@(posedge clk)
    !rstPowerN |-> !breakIrq); // R1
endmodule

// File: tb/sim_bus_break_unit.sv
module sim_bus_break_unit;
  logic clk = 0, rstPowerN = 0, softReset = 0, regWr = 0;
  logic [2:0] regSel = 0;
  logic [1:0] regByteEn = 0, busSize = 0;
  logic [15:0] regWdata = 0, regRdata, xAddr = 0, yAddr = 0;
  logic busValid = 0, busDma = 0, busData = 0, busWrite = 0, breakIrq;
  logic [31:0] busAddr = 0;

  bus_break_unit u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;

  // behavioural reference model
  logic [15:0] mReg [0:4];
  logic mFlag;

  function automatic bit kindM(input logic [1:0] f, input logic s);
    if (f == 0) return 0;
    if (f == 3) return 1;
    return (f == 1) ? (s == 0) : (s == 1);
  endfunction

  function automatic bit hitM();
    logic [15:0] c;
    bit a;
    c = mReg[4];
    if (!busValid) return 0;
    if (!c[9]) a = (((busAddr ^ {mReg[0], mReg[1]}) & ~{mReg[2], mReg[3]}) == 0);
    else if (!c[8]) a = (xAddr[15:1] & ~mReg[2][15:1]) == (mReg[0][15:1] & ~mReg[2][15:1]);
    else a = (yAddr[15:1] & ~mReg[3][15:1]) == (mReg[1][15:1] & ~mReg[3][15:1]);
    return a && kindM(c[7:6], busDma) && kindM(c[5:4], busData) && kindM(c[3:2], busWrite)
           && (c[1:0] == 0 || c[1:0] == busSize);
  endfunction

  always @(posedge clk or negedge rstPowerN) begin
    if (!rstPowerN) begin
      for (int i = 0; i < 5; i++) mReg[i] <= 0;
      mFlag <= 0;
    end else begin
      bit h;
      h = hitM();
      if (regWr && regSel < 5) begin
        logic [15:0] v;
        v = mReg[regSel];
        if (regByteEn[0]) v[7:0] = regWdata[7:0];
        if (regByteEn[1]) v[15:8] = regWdata[15:8];
        if (regSel == 4) v[14:10] = 0;
        mReg[regSel] <= v;
      end
      if (softReset) mFlag <= 0;
      else if (h) mFlag <= 1;
      else if (regWr && regSel == 5 && regByteEn[0] && regWdata[0]) mFlag <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model (R8, R7)
  always @(negedge clk) if (rstPowerN) begin
    chk("R8 irq vs model", breakIrq, mFlag & mReg[4][15]);
  end

  task automatic wr(input logic [2:0] s, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    regWr = 1; regSel = s; regByteEn = be; regWdata = d;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] s, input logic [15:0] exp);
    @(negedge clk);
    regSel = s;
    #1 chk(tag, regRdata, exp);
  endtask

  task automatic cyc(input logic [31:0] a, input logic [15:0] x, input logic [15:0] y,
                     input logic dma, input logic dat, input logic w, input logic [1:0] sz);
    @(negedge clk);
    busValid = 1; busAddr = a; xAddr = x; yAddr = y;
    busDma = dma; busData = dat; busWrite = w; busSize = sz;
    @(negedge clk);
    busValid = 0;
  endtask

  task automatic clr();
    wr(3'd5, 2'b01, 16'h0001);
  endtask

  task automatic hitChk(input string tag, input logic exp);
    #1 chk(tag, breakIrq, exp);
    clr();
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) rd("R1 reset readback", 3'(i), 16'h0);
    chk("R1 irq in reset", breakIrq, 1'b0);
    rstPowerN = 1;

    wr(0, 2'b11, 16'h1234); wr(1, 2'b11, 16'h5678);
    wr(4, 2'b11, 16'hFFFF);
    rd("R8 reserved bits read 0", 4, 16'h83FF);
    wr(4, 2'b11, 16'h80FC);             // ie, cp/id/rw any, sz any
    cyc(32'h12345678, 0, 0, 0, 0, 0, 2'b11); hitChk("R3 exact match", 1);
    cyc(32'h12345679, 0, 0, 0, 0, 0, 2'b11); hitChk("R3 bit0 differs", 0);
    wr(3, 2'b01, 16'h00FF);
    cyc(32'h123456AB, 0, 0, 1, 1, 1, 2'b01); hitChk("R3 masked low byte", 1);
    cyc(32'h123457AB, 0, 0, 1, 1, 1, 2'b01); hitChk("R3 unmasked bit differs", 0);

    wr(3, 2'b10, 16'hAB00);
    rd("R9 byte enable high only", 3, 16'hABFF);
    wr(3, 2'b11, 16'h0000);

    wr(4, 2'b01, 16'h007C);             // cp=01 CPU only
    cyc(32'h12345678, 0, 0, 1, 0, 0, 0); hitChk("R5 cp CPU rejects DMA", 0);
    cyc(32'h12345678, 0, 0, 0, 0, 0, 0); hitChk("R5 cp CPU accepts CPU", 1);
    wr(4, 2'b01, 16'h003C);             // cp=00 never
    cyc(32'h12345678, 0, 0, 0, 0, 0, 0); hitChk("R5 cp 00 never", 0);
    wr(4, 2'b01, 16'h00E8);             // id=10 data, rw=10 write
    cyc(32'h12345678, 0, 0, 1, 1, 0, 0); hitChk("R5 rw write rejects read", 0);
    cyc(32'h12345678, 0, 0, 1, 1, 1, 0); hitChk("R5 data write accepted", 1);
    cyc(32'h12345678, 0, 0, 1, 0, 1, 0); hitChk("R5 id data rejects fetch", 0);

    wr(4, 2'b01, 16'h00FE);             // sz=10 word
    cyc(32'h12345678, 0, 0, 0, 0, 0, 2'b01); hitChk("R6 word rejects byte", 0);
    cyc(32'h12345678, 0, 0, 0, 0, 0, 2'b10); hitChk("R6 word accepts word", 1);

    wr(0, 2'b11, 16'h0040); wr(1, 2'b11, 16'h0A00);
    wr(4, 2'b11, 16'h82FC);             // xye=1 xys=0
    cyc(32'h0, 16'h0041, 16'h0, 0, 0, 0, 0); hitChk("R4 X bit0 ignored", 1);
    cyc(32'h0, 16'h0042, 16'h0A00, 0, 0, 0, 0); hitChk("R4 X mismatch", 0);
    wr(4, 2'b11, 16'h83FC);             // xys=1
    cyc(32'h0, 16'h0040, 16'h0A01, 0, 0, 0, 0); hitChk("R4 Y bit0 ignored", 1);
    wr(3, 2'b11, 16'h0002);
    cyc(32'h0, 16'h0, 16'h0A02, 0, 0, 0, 0); hitChk("R4 Y masked bit1", 1);

    // clear and match in the same cycle: match wins
    @(negedge clk);
    busValid = 1; yAddr = 16'h0A00; regWr = 1; regSel = 5; regByteEn = 1; regWdata = 1;
    @(negedge clk);
    busValid = 0; regWr = 0;
    rd("R7 set wins over clear", 5, 16'h0001);
    wr(4, 2'b10, 16'h0300);             // ie=0
    rd("R7 flag sticky with ie off", 5, 16'h0001);
    #1 chk("R8 irq gated by ie", breakIrq, 0);

    @(negedge clk); softReset = 1; @(negedge clk); softReset = 0;
    rd("R2 soft reset clears flag", 5, 16'h0);
    rd("R2 mask kept", 3, 16'h0002);
    rd("R2 cycle kept", 4, 16'h03FC);
    rd("R2 addr kept", 0, 16'h0040);

    @(negedge clk); rstPowerN = 0; #1;
    rd("R1 power reset clears cycle", 4, 16'h0);
    rd("R1 power reset clears addr", 1, 16'h0);
    rstPowerN = 1;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule